// File: doc/BRIEF.md
# Prioritized Reset and Interrupt Sequencer

This block decides when a small processor core gets redirected. Five reset request lines are merged into one core reset. After the last request goes away, the core is held in reset for a fixed number of stabilization cycles. It is then released with a one-cycle vector-load pulse that carries address zero. The block also keeps a record of which request lines caused the most recent reset sequence.

Once the core is running, the block watches a vector of pending interrupt requests. It redirects the core only at an instruction boundary and only while the global interrupt enable is set. The lowest-numbered pending request wins, and its number n becomes the word address 2n. Each vector therefore has room for a two-word jump. Taking an interrupt clears the global enable. A set-enable request or a return-from-interrupt request sets it again. Fetch, decode and saving the return address are left to the core.

Top module: `boot_irq_sequencer`

## Requirements
- R1: Any one of the five request inputs (porReq, extReq, wdtReq, bodReq, dbgReq) puts coreReset high from the next clock edge on. coreReset stays high while any of them is high.
- R2: After the last clock edge that samples a request high, coreReset stays high for DELAY_CYCLES-1 more cycles. No vecLoad appears during that time. On the DELAY_CYCLES-th edge, coreReset falls and vecLoad is high for exactly one cycle, with vecAddr = 0 and vecTaken low.
- R3: If a request line rises again while the stabilization count is running, the count restarts. A full DELAY_CYCLES must then pass after that line falls.
- R4: resetCause uses bit 0 for power-on, bit 1 for the external pin, bit 2 for the watchdog, bit 3 for brown-out and bit 4 for the debug port. A reset that begins from the running state loads the lines that are high. Lines that rise later in the same sequence, up to release, are ORed in.
- R5: A causeClr pulse zeroes resetCause on the next edge. While any request line is high, causeClr has no effect.
- R6: gie is low during reset and after release. A seiReq pulse in the running state sets gie on the next edge. seiReq has no effect while coreReset is high.
- R7: An interrupt is taken on the edge that samples irqBoundary high, gie high and at least one irqReq bit set. In the following cycle, vecLoad and vecTaken are both high for one cycle.
- R8: When several irqReq bits are set, the lowest index n wins, and vecAddr = 2n during the vecTaken cycle.
- R9: Taking an interrupt clears gie, even if seiReq or retiReq is high on the same edge. A later retiReq pulse sets gie again.
- R10: No interrupt is taken when irqBoundary is low or gie is low, even with requests pending. vecTaken stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porReq | input | 1 | Power-on reset request |
| extReq | input | 1 | External pin reset request |
| wdtReq | input | 1 | Watchdog reset request |
| bodReq | input | 1 | Brown-out reset request |
| dbgReq | input | 1 | Debug/test port reset request |
| causeClr | input | 1 | Clear strobe for resetCause |
| irqReq | input | NUM_IRQ | Pending interrupt requests, bit 0 most urgent |
| irqBoundary | input | 1 | Core is between execute and the next fetch |
| seiReq | input | 1 | Set global interrupt enable |
| retiReq | input | 1 | Return from interrupt, re-enables interrupts |
| coreReset | output | 1 | Holds the core in reset |
| vecLoad | output | 1 | One-cycle pulse: load PC from vecAddr and fetch |
| vecTaken | output | 1 | One-cycle pulse: the vecLoad is for an interrupt |
| vecAddr | output | PC_W | Vector word address |
| gie | output | 1 | Global interrupt enable |
| resetCause | output | 5 | Request lines of the most recent reset sequence |

## Verification
The assertions assume the request lines are synchronous to clk. They also assume that irqReq, irqBoundary, seiReq and retiReq are stable for the whole cycle in which they are sampled. Every property is switched off while any request line is high. The bench changes all inputs only on the falling clock edge and samples outputs there, so it stays within these assumptions. It sweeps every nonzero combination of request lines and every nonzero interrupt pattern.

// File: rtl/boot_irq_pkg.sv
package boot_irq_pkg;
  localparam int unsigned NUM_SRC = 5;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic bootSet;
    logic takeSet;
    logic causeFresh;
    logic causeMerge;
    logic causeClr;
  } seqStrobes_t;
endpackage

// File: rtl/boot_irq_ctrl.sv
module boot_irq_ctrl
  import boot_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rawRst,
  input  logic        irqBoundary,
  input  logic        seiReq,
  input  logic        retiReq,
  input  logic        causeClr,
  input  logic        cntDone,
  input  logic        irqAny,
  output seqStrobes_t strobes,
  output logic        gie,
  output logic        coreReset
);
  seqState_t state, stateNext;
  logic gieNext;
  logic takeNow;

  assign takeNow = (state == ST_RUN) && !rawRst && irqBoundary && gie && irqAny;

  always_comb begin
    stateNext = state;
    gieNext   = gie;
    strobes   = '0;
    if (rawRst) begin
      stateNext          = ST_HOLD;
      gieNext            = 1'b0;
      strobes.cntClr     = 1'b1;
      strobes.causeFresh = (state == ST_RUN);
      strobes.causeMerge = (state == ST_HOLD);
    end else begin
      strobes.causeClr = causeClr;
      if (state == ST_HOLD) begin
        gieNext = 1'b0;
        if (cntDone) begin
          stateNext       = ST_RUN;
          strobes.bootSet = 1'b1;
        end else begin
          strobes.cntInc = 1'b1;
        end
      end else if (takeNow) begin
        strobes.takeSet = 1'b1;
        gieNext         = 1'b0;
      end else if (seiReq || retiReq) begin
        gieNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    state <= stateNext;
    gie   <= gieNext;
  end

  assign coreReset = (state == ST_HOLD);
endmodule

// File: rtl/boot_irq_datapath.sv
module boot_irq_datapath
  import boot_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ      = 8,
  parameter int unsigned DELAY_CYCLES = 12,
  parameter int unsigned PC_W         = 16
) (
  input  logic               clk,
  input  seqStrobes_t        strobes,
  input  logic [NUM_SRC-1:0] srcVec,
  input  logic [NUM_IRQ-1:0] irqReq,
  output logic               cntDone,
  output logic               irqAny,
  output logic               bootPulse,
  output logic               takePulse,
  output logic [PC_W-1:0]    vecAddr,
  output logic [NUM_SRC-1:0] resetCause
);
  localparam int unsigned CW = $clog2(DELAY_CYCLES + 1);
  localparam int unsigned IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [CW-1:0] cnt;
  logic [IW-1:0] winner;

  assign cntDone = (cnt == CW'(DELAY_CYCLES - 1));
  assign irqAny  = |irqReq;

  always_comb begin
    winner = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irqReq[i]) winner = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.cntClr)      cnt <= '0;
    else if (strobes.cntInc) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.causeFresh)      resetCause <= srcVec;
    else if (strobes.causeMerge) resetCause <= resetCause | srcVec;
    else if (strobes.causeClr)   resetCause <= '0;
  end

  always_ff @(posedge clk) begin
    bootPulse <= strobes.bootSet;
    takePulse <= strobes.takeSet;
    if (strobes.cntClr || strobes.bootSet) vecAddr <= '0;
    else if (strobes.takeSet)              vecAddr <= PC_W'({winner, 1'b0});
  end
endmodule

// File: rtl/boot_irq_sequencer.sv
module boot_irq_sequencer
  import boot_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ      = 8,
  parameter int unsigned DELAY_CYCLES = 12,
  parameter int unsigned PC_W         = 16
) (
  input  logic               clk,
  input  logic               porReq,
  input  logic               extReq,
  input  logic               wdtReq,
  input  logic               bodReq,
  input  logic               dbgReq,
  input  logic               causeClr,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               irqBoundary,
  input  logic               seiReq,
  input  logic               retiReq,
  output logic               coreReset,
  output logic               vecLoad,
  output logic               vecTaken,
  output logic [PC_W-1:0]    vecAddr,
  output logic               gie,
  output logic [4:0]         resetCause
);
  logic [NUM_SRC-1:0] srcVec;
  logic rawRst, cntDone, irqAny, bootPulse, takePulse;
  seqStrobes_t strobes;

  assign srcVec = {dbgReq, bodReq, wdtReq, extReq, porReq};
  assign rawRst = |srcVec;

  boot_irq_ctrl u_ctrl (
    .clk(clk), .rawRst(rawRst), .irqBoundary(irqBoundary), .seiReq(seiReq),
    .retiReq(retiReq), .causeClr(causeClr), .cntDone(cntDone), .irqAny(irqAny),
    .strobes(strobes), .gie(gie), .coreReset(coreReset)
  );

  boot_irq_datapath #(
    .NUM_IRQ(NUM_IRQ), .DELAY_CYCLES(DELAY_CYCLES), .PC_W(PC_W)
  ) u_dp (
    .clk(clk), .strobes(strobes), .srcVec(srcVec), .irqReq(irqReq),
    .cntDone(cntDone), .irqAny(irqAny), .bootPulse(bootPulse),
    .takePulse(takePulse), .vecAddr(vecAddr), .resetCause(resetCause)
  );

  assign vecLoad  = bootPulse | takePulse;
  assign vecTaken = takePulse;
endmodule

// File: rtl/boot_irq_seq_chk.sv
module boot_irq_seq_chk #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PC_W    = 16
) (
  input logic               clk,
  input logic               porReq,
  input logic               extReq,
  input logic               wdtReq,
  input logic               bodReq,
  input logic               dbgReq,
  input logic [NUM_IRQ-1:0] irqReq,
  input logic               irqBoundary,
  input logic               seiReq,
  input logic               retiReq,
  input logic               coreReset,
  input logic               vecLoad,
  input logic               vecTaken,
  input logic [PC_W-1:0]    vecAddr,
  input logic               gie
);
  logic anyReq;
  assign anyReq = porReq | extReq | wdtReq | bodReq | dbgReq;

  function automatic logic [PC_W-1:0] lowestAddr(input logic [NUM_IRQ-1:0] v);
    logic [PC_W-1:0] r;
    r = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (v[i]) r = PC_W'(2 * i);
    end
    return r;
  endfunction

  // R2
  reset_blocks_load_chk: assert property (@(posedge clk) disable iff (anyReq)
    coreReset |-> !vecLoad);

  // R2
  release_loads_zero_chk: assert property (@(posedge clk) disable iff (anyReq)
    $fell(coreReset) |-> (vecLoad && !vecTaken && vecAddr == '0));

  // R6
  gie_low_in_reset_chk: assert property (@(posedge clk) disable iff (anyReq)
    coreReset |-> !gie);

  // R7
  take_conditions_chk: assert property (@(posedge clk) disable iff (anyReq)
    vecTaken |-> ($past(gie) && $past(irqBoundary) && ($past(irqReq) != '0) && vecLoad));

  // R8
  take_priority_chk: assert property (@(posedge clk) disable iff (anyReq)
    vecTaken |-> (vecAddr == lowestAddr($past(irqReq))));

  // R9
  take_clears_gie_chk: assert property (@(posedge clk) disable iff (anyReq)
    vecTaken |-> !gie);

  // R6
  gie_rise_needs_request_chk: assert property (@(posedge clk) disable iff (anyReq)
    $rose(gie) |-> ($past(seiReq) || $past(retiReq)));
endmodule

bind boot_irq_sequencer boot_irq_seq_chk #(.NUM_IRQ(NUM_IRQ), .PC_W(PC_W)) u_chk (
  .clk(clk), .porReq(porReq), .extReq(extReq), .wdtReq(wdtReq), .bodReq(bodReq),
  .dbgReq(dbgReq), .irqReq(irqReq), .irqBoundary(irqBoundary), .seiReq(seiReq),
  .retiReq(retiReq), .coreReset(coreReset), .vecLoad(vecLoad), .vecTaken(vecTaken),
  .vecAddr(vecAddr), .gie(gie)
);

// File: tb/tb_boot_irq_sequencer.sv
module tb_boot_irq_sequencer;
  localparam int NI = 8;
  localparam int DLY = 12;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic porReq = 1'b1, extReq = 1'b0, wdtReq = 1'b0, bodReq = 1'b0, dbgReq = 1'b0;
  logic causeClr = 1'b0, irqBoundary = 1'b0, seiReq = 1'b0, retiReq = 1'b0;
  logic [NI-1:0] irqReq = '0;
  logic coreReset, vecLoad, vecTaken, gie;
  logic [PW-1:0] vecAddr;
  logic [4:0] resetCause;

  int total = 0, failed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  boot_irq_sequencer #(.NUM_IRQ(NI), .DELAY_CYCLES(DLY), .PC_W(PW)) dut (
    .clk(clk), .porReq(porReq), .extReq(extReq), .wdtReq(wdtReq), .bodReq(bodReq),
    .dbgReq(dbgReq), .causeClr(causeClr), .irqReq(irqReq), .irqBoundary(irqBoundary),
    .seiReq(seiReq), .retiReq(retiReq), .coreReset(coreReset), .vecLoad(vecLoad),
    .vecTaken(vecTaken), .vecAddr(vecAddr), .gie(gie), .resetCause(resetCause)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setSrc(input logic [4:0] s);
    {dbgReq, bodReq, wdtReq, extReq, porReq} = s;
  endtask

  // Counts the stabilization window after the sources drop and checks release.
  task automatic releaseAndCount(input logic [4:0] expCause);
    setSrc(5'b0);
    for (int i = 1; i <= DLY; i++) begin
      tick();
      if (i < DLY) begin
        if (coreReset !== 1'b1 || vecLoad !== 1'b0)
          check(0, "R2", "early release/fetch", {30'b0, coreReset, vecLoad}, 2);
      end else begin
        check(coreReset == 1'b0 && vecLoad == 1'b1 && vecTaken == 1'b0,
              "R2", "release pulse", {29'b0, coreReset, vecLoad, vecTaken}, 2);
        check(vecAddr == 0, "R2", "boot vector", int'(vecAddr), 0);
        check(resetCause == expCause, "R4", "cause", int'(resetCause), int'(expCause));
        check(gie == 1'b0, "R6", "gie after release", int'(gie), 0);
      end
    end
    tick();
    check(vecLoad == 1'b0, "R2", "pulse length", int'(vecLoad), 0);
  endtask

  function automatic int lowest(input logic [NI-1:0] v);
    for (int i = 0; i < NI; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    check(coreReset == 1'b1 && vecLoad == 1'b0, "R1", "reset state",
          {30'b0, coreReset, vecLoad}, 2);
    check(gie == 1'b0, "R6", "gie in reset", int'(gie), 0);
    releaseAndCount(5'b00001);

    // R1 R4: every nonzero combination of request lines
    for (int s = 1; s < 32; s++) begin
      setSrc(5'(s));
      seiReq = 1'b1;   // R6: ignored during reset
      tick();
      seiReq = 1'b0;
      check(coreReset == 1'b1, "R1", "source asserts reset", int'(coreReset), 1);
      check(resetCause == 5'(s), "R4", "fresh capture", int'(resetCause), s);
      releaseAndCount(5'(s));
    end

    // R3 R4: restart of count and merge within one sequence
    setSrc(5'b00010);
    tick();
    setSrc(5'b0);
    repeat (5) tick();
    setSrc(5'b00100);
    tick();
    check(coreReset == 1'b1, "R3", "still held", int'(coreReset), 1);
    releaseAndCount(5'b00110);

    // R5: clear strobe in run, ignored while a line is high
    causeClr = 1'b1;
    tick();
    causeClr = 1'b0;
    check(resetCause == 0, "R5", "cleared", int'(resetCause), 0);
    setSrc(5'b01000);
    causeClr = 1'b1;
    tick();
    causeClr = 1'b0;
    check(resetCause == 5'b01000, "R5", "clear ignored in reset", int'(resetCause), 8);
    releaseAndCount(5'b01000);

    // R10: gie low blocks take
    irqReq = 8'h01;
    irqBoundary = 1'b1;
    tick();
    tick();
    check(vecTaken == 1'b0, "R10", "no take while gie low", int'(vecTaken), 0);
    irqBoundary = 1'b0;
    irqReq = '0;

    // R6: set enable
    seiReq = 1'b1;
    tick();
    seiReq = 1'b0;
    check(gie == 1'b1, "R6", "sei sets gie", int'(gie), 1);

    // R7 R8 R9 R10: every nonzero pending pattern
    for (int p = 1; p < 256; p++) begin
      irqReq = 8'(p);
      irqBoundary = 1'b0;
      tick();
      tick();
      check(vecTaken == 1'b0 && gie == 1'b1, "R10", "no take off boundary",
            {30'b0, vecTaken, gie}, 1);
      irqBoundary = 1'b1;
      seiReq = (p % 3 == 0);
      retiReq = (p % 5 == 0);
      tick();
      irqBoundary = 1'b0;
      seiReq = 1'b0;
      retiReq = 1'b0;
      irqReq = '0;
      check(vecTaken == 1'b1 && vecLoad == 1'b1, "R7", "take pulse",
            {30'b0, vecTaken, vecLoad}, 3);
      check(int'(vecAddr) == 2 * lowest(8'(p)), "R8", "vector address",
            int'(vecAddr), 2 * lowest(8'(p)));
      check(gie == 1'b0, "R9", "take clears gie", int'(gie), 0);
      tick();
      check(vecTaken == 1'b0, "R7", "single pulse", int'(vecTaken), 0);
      retiReq = 1'b1;
      tick();
      retiReq = 1'b0;
      check(gie == 1'b1, "R9", "reti sets gie", int'(gie), 1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule